// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog that software must service at regular intervals. Three 32-bit registers sit on a simple single-cycle register bus. The mode register turns the watchdog on and selects the timeout from a coded, non-linear table. The configuration register selects what happens at expiry and holds a sticky interrupt flag. The control register accepts restart commands, but only when a restart bit arrives together with a fixed 12-bit key.

A prescaler divides the input clock into a half-second tick, and the countdown runs in half-second units. If the countdown reaches its end before a valid restart, the block either drives a system-reset request for a fixed number of clocks or sets the interrupt flag. It then reloads and keeps counting. The reset controller, clock generation and any bus bridge are outside the block.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every register reads 0, the watchdog is disabled, and both `sys_rst_req` and `irq` are low.
- R2: Register offsets are 0x10 (control), 0x14 (configuration) and 0x18 (mode). Mode reads back bit 0 as the enable and bits 7:4 as the interval code. Configuration reads back bits 1:0 as the action and bit 8 as the interrupt flag. Every other bit reads 0, and the control register always reads 0.
- R3: A control write whose bits 12:0 equal 0x14AF (bit 0 = 1, bits 12:1 = 0xA57) restarts the countdown. Expiry then follows exactly N×HALF_SEC_CYCLES clocks after that write edge, where N is the half-second count of the current code.
- R4: A control write with any other value in bits 12:0 has no effect on when expiry occurs.
- R5: Interval codes give these half-second counts N: 0x0 gives 1, 0x1 to 0x6 give 2 to 12, and 0x7, 0x8, 0x9, 0xA and 0xB give 16, 20, 24, 28 and 32.
- R6: Reserved codes 0xC to 0xF behave like code 0xB (N = 32).
- R7: A mode write that enables a disabled watchdog, or that changes the code while it is enabled, reloads the countdown at that write edge. Rewriting the same code while enabled does not reload it.
- R8: Writing 0 to the mode register stops the watchdog, and no expiry follows.
- R9: With action 01, expiry drives `sys_rst_req` high for exactly PULSE_CYCLES (16) clocks, starting at the expiry edge.
- R10: With action 10, expiry sets the sticky `irq` flag. A configuration write with bit 8 = 1 clears it. A write with bit 8 = 0 leaves it set.
- R11: Actions 00 and 11 drive neither `sys_rst_req` nor `irq` at expiry.
- R12: After an expiry, the countdown reloads and expires again N×HALF_SEC_CYCLES clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sys_rst_req | output | 1 | System-reset request pulse |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
A wrong countdown or prescaler state shows at the ports as an expiry edge that arrives early or late. That edge is visible within one interval of the last reload: at most 32 ticks, or 128 clocks in the bench configuration. A wrong reload decision, such as a bad key accepted or a same-code rewrite that reloads, moves that edge, so each check looks for the edge in the exact cycle it should appear and confirms the output is still low one cycle before. A corrupted action or flag state shows at once as the wrong output rising, or as a wrong configuration read-back.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int HALF_SEC_CYCLES = 25_000_000,
  parameter int PULSE_CYCLES    = 16,
  parameter int ADDR_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req,
  output logic              irq
);
  localparam int PW = (HALF_SEC_CYCLES > 1) ? $clog2(HALF_SEC_CYCLES) : 1;
  localparam int RW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(HALF_SEC_CYCLES - 1);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] CFG_OFS  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] MODE_OFS = ADDR_W'(8'h18);
  localparam logic [12:0] RESTART_WORD = 13'h14AF;

  logic          en;
  logic [3:0]    code;
  logic [1:0]    act;
  logic          irq_q;
  logic [5:0]    cnt;
  logic [PW-1:0] presc;
  logic [RW-1:0] rst_left;

  function automatic logic [5:0] half_units(input logic [3:0] c);
    if (c == 4'h0)      half_units = 6'd1;
    else if (c <= 4'h6) half_units = {1'b0, c, 1'b0};
    else if (c <= 4'hB) half_units = 6'({c, 2'b00} - 6'd12);
    else                half_units = 6'd32;
  endfunction

  wire wr_ctrl = bus_en & bus_wr & (bus_addr == CTRL_OFS);
  wire wr_cfg  = bus_en & bus_wr & (bus_addr == CFG_OFS);
  wire wr_mode = bus_en & bus_wr & (bus_addr == MODE_OFS);

  wire       restart     = wr_ctrl & (bus_wdata[12:0] == RESTART_WORD);
  wire       new_en      = bus_wdata[0];
  wire [3:0] new_code    = bus_wdata[7:4];
  wire       mode_reload = wr_mode & new_en & (!en | (new_code != code));
  wire       mode_stop   = wr_mode & !new_en;
  wire       reload      = restart | mode_reload;
  wire [3:0] load_code   = mode_reload ? new_code : code;

  wire tick   = en & (presc == PRESC_LAST);
  wire expire = tick & (cnt == 6'd1) & !reload & !mode_stop;

  logic unused_bits;
  assign unused_bits = ^bus_wdata[31:13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      code     <= 4'h0;
      act      <= 2'b00;
      irq_q    <= 1'b0;
      cnt      <= 6'd0;
      presc    <= '0;
      rst_left <= '0;
    end else begin
      if (wr_mode) begin
        en   <= new_en;
        code <= new_code;
      end
      if (wr_cfg) act <= bus_wdata[1:0];

      if (expire && act == 2'b10)       irq_q <= 1'b1;
      else if (wr_cfg && bus_wdata[8])  irq_q <= 1'b0;

      if (reload) begin
        cnt   <= half_units(load_code);
        presc <= '0;
      end else if (en) begin
        if (tick) begin
          presc <= '0;
          cnt   <= (cnt == 6'd1) ? half_units(code) : cnt - 6'd1;
        end else begin
          presc <= presc + 1'b1;
        end
      end

      if (expire && act == 2'b01)  rst_left <= RW'(PULSE_CYCLES);
      else if (rst_left != '0)     rst_left <= rst_left - 1'b1;
    end
  end

  assign sys_rst_req = (rst_left != '0);
  assign irq         = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      if (bus_addr == CFG_OFS)       bus_rdata = {23'd0, irq_q, 6'd0, act};
      else if (bus_addr == MODE_OFS) bus_rdata = {24'd0, code, 3'd0, en};
    end
  end

  assert_ctrl_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && bus_addr == CTRL_OFS) |-> bus_rdata == 32'd0);

  assert_rst_only_reset_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> act == 2'b01);

  assert_irq_only_irq_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(act) == 2'b10);

  assert_stopped_no_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(sys_rst_req) && !$rose(irq));

  assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt != 6'd0) && (cnt <= 6'd32));

  assert_bad_key_no_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !restart && en && !tick) |=> cnt == $past(cnt));
endmodule

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
  localparam int H = 4;
  localparam int PULSE = 16;
  localparam logic [7:0] A_CTRL = 8'h10, A_CFG = 8'h14, A_MODE = 8'h18;

  logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic sys_rst_req, irq;
  int n_chk = 0, n_fail = 0;
  longint cyc = 0;

  keyed_wdog #(.HALF_SEC_CYCLES(H), .PULSE_CYCLES(PULSE), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int units(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 10; 6: return 12; 7: return 16;
      8: return 20; 9: return 24; 10: return 28;
      default: return 32;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, a, e, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output longint edge_no);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    edge_no = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wait_to(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] d;
    longint e, w, base;
    int lh;
    bit bad;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(A_CFG, d);  chk(d == 0, "R1 cfg", d, 0);
    rd(A_MODE, d); chk(d == 0, "R1 mode", d, 0);
    chk(!sys_rst_req && !irq, "R1 outputs", {sys_rst_req, irq}, 0);

    // R2 read-back of stored fields only
    wr(A_CFG, 32'hFFFF_FEFE, e);  rd(A_CFG, d);  chk(d == 32'h2, "R2 cfg", d, 32'h2);
    wr(A_MODE, 32'hFFFF_FFF0, e); rd(A_MODE, d); chk(d == 32'hF0, "R2 mode", d, 32'hF0);
    wr(A_CTRL, 32'h0000_14AF, e); rd(A_CTRL, d); chk(d == 0, "R2 ctrl", d, 0);
    wr(A_MODE, 0, e);

    // R5 R6 interval table, interrupt action
    for (int c = 0; c < 16; c++) begin
      wr(A_MODE, 0, e);
      wr(A_CFG, 32'h102, e);
      wr(A_MODE, (c << 4) | 1, e);
      lh = units(c) * H;
      wait_to(e + lh - 1);
      chk(!irq, c > 11 ? "R6 early" : "R5 early", irq, 0);
      wait_to(e + lh);
      chk(irq, c > 11 ? "R6 expiry" : "R5 expiry", irq, 1);
      chk(!sys_rst_req, "R11 no reset with irq action", sys_rst_req, 0);
    end

    // R12 periodic, R10 clear semantics
    wr(A_MODE, 0, e); wr(A_CFG, 32'h102, e);
    wr(A_MODE, 32'h11, e);
    wait_to(e + 8); chk(irq, "R12 first expiry", irq, 1);
    wr(A_CFG, 32'h002, w); chk(irq, "R10 bit8=0 keeps flag", irq, 1);
    rd(A_CFG, d); chk(d == 32'h102, "R10 flag readback", d, 32'h102);
    wr(A_CFG, 32'h102, w); chk(!irq, "R10 clear", irq, 0);
    wait_to(e + 15); chk(!irq, "R12 before second expiry", irq, 0);
    wait_to(e + 16); chk(irq, "R12 second expiry", irq, 1);

    // R9 reset pulse length, R3 restart
    wr(A_MODE, 0, e); wr(A_CFG, 32'h101, e);
    wr(A_MODE, 32'hB1, e);
    wait_to(e + 127); chk(!sys_rst_req, "R9 before expiry", sys_rst_req, 0);
    wait_to(e + 128); chk(sys_rst_req, "R9 pulse start", sys_rst_req, 1);
    wait_to(e + 128 + PULSE - 1); chk(sys_rst_req, "R9 pulse last", sys_rst_req, 1);
    wait_to(e + 128 + PULSE); chk(!sys_rst_req, "R9 pulse end", sys_rst_req, 0);
    chk(!irq, "R11 no irq with reset action", irq, 0);
    wait_to(e + 200);
    wr(A_CTRL, 32'hFFFF_F4AF, w);
    wait_to(e + 256); chk(!sys_rst_req, "R3 old expiry suppressed", sys_rst_req, 0);
    wait_to(w + 127); chk(!sys_rst_req, "R3 before restarted expiry", sys_rst_req, 0);
    wait_to(w + 128); chk(sys_rst_req, "R3 restarted expiry", sys_rst_req, 1);

    // R4 bad keys
    wr(A_MODE, 0, e); repeat (PULSE + 2) @(negedge clk);
    wr(A_MODE, 32'h31, e);
    wr(A_CTRL, 32'h0000_14AE, w);
    wr(A_CTRL, 32'h0000_14AD, w);
    wr(A_CTRL, 32'h0000_0001, w);
    wr(A_CTRL, 32'hFFFF_FFFF, w);
    wait_to(e + 23); chk(!sys_rst_req, "R4 before expiry", sys_rst_req, 0);
    wait_to(e + 24); chk(sys_rst_req, "R4 expiry unchanged", sys_rst_req, 1);

    // R7 same-code rewrite vs code change
    wr(A_MODE, 0, e); wr(A_CFG, 32'h102, e);
    wr(A_MODE, 32'h41, e);
    wr(A_MODE, 32'h41, w);
    wait_to(e + 31); chk(!irq, "R7 same code early", irq, 0);
    wait_to(e + 32); chk(irq, "R7 same code no reload", irq, 1);
    wr(A_CFG, 32'h102, w);
    wr(A_MODE, 32'h21, w);
    wait_to(w + 15); chk(!irq, "R7 code change early", irq, 0);
    wait_to(w + 16); chk(irq, "R7 code change reload", irq, 1);

    // R8 stop
    wr(A_MODE, 0, e); wr(A_CFG, 32'h101, e); repeat (PULSE + 2) @(negedge clk);
    wr(A_MODE, 32'h01, e);
    wr(A_MODE, 0, e);
    bad = 0;
    repeat (100) begin @(negedge clk); if (sys_rst_req) bad = 1; end
    chk(!bad, "R8 no expiry after stop", bad, 0);
    rd(A_MODE, d); chk(d == 0, "R8 mode reads 0", d, 0);

    // R11 actions 00 and 11
    for (int a = 0; a < 4; a += 3) begin
      wr(A_CFG, a | 32'h100, e);
      wr(A_MODE, 32'h01, e);
      bad = 0;
      repeat (30) begin @(negedge clk); if (sys_rst_req || irq) bad = 1; end
      chk(!bad, "R11 silent action", bad, 0);
      wr(A_MODE, 0, e);
    end

    // random mix: R3 R5 R9 R10
    for (int it = 0; it < 12; it++) begin
      int c, a, o;
      c = $urandom % 16;
      a = ($urandom % 2) ? 1 : 2;
      lh = units(c) * H;
      wr(A_MODE, 0, e); repeat (PULSE + 2) @(negedge clk);
      wr(A_CFG, a | 32'h100, e);
      wr(A_MODE, (c << 4) | 1, base);
      if ($urandom % 2) begin
        o = (lh > 3) ? ($urandom % (lh - 3)) : 0;
        wait_to(base + o);
        wr(A_CTRL, 32'h14AF, base);
      end
      wait_to(base + lh - 1);
      chk(!(a == 1 ? sys_rst_req : irq), "R3 random early", 1, 0);
      wait_to(base + lh);
      chk(a == 1 ? sys_rst_req : irq, a == 1 ? "R9 random expiry" : "R10 random expiry", 0, 1);
    end

    summary();
  end
endmodule